// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural integer registers of a 32-bit processor core: sixteen logical registers of 32 bits each. Some of them are backed by private physical copies that are swapped in whenever the processor's operating mode changes. It also keeps the current status word and one saved status word for each privileged mode. Decode, arithmetic, memory access and program-counter stepping sit outside the block. Logical index 15 is the program counter, 14 is the link register and 13 is the stack pointer. All three are reached like any other index.

The operating mode is the five-bit field in the low bits of the current status word. Writing a new status word through the status write strobe is how the surrounding core changes mode. From the following cycle, each logical index resolves to the physical storage that belongs to the new mode. The two read ports are combinational. The single register write port, the current-status write and the saved-status write all take effect at the rising clock edge.

Mode encodings (bits 4:0 of the status word): user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. Status word layout:

| Bits | Field |
|------|-------|
| 31 | N flag |
| 30 | Z flag |
| 29 | C flag |
| 28 | V flag |
| 7 | interrupt mask; 1 masks the interrupt, 0 enables it |
| 6 | fast-interrupt mask; 1 masks it, 0 enables it |
| 5 | instruction-set bit |
| 4:0 | mode field |

Top module: `bankreg_file`

## Requirements
- R1: While reset is low, and after it is released, the current status word reads 0x000000D3: supervisor mode, both mask bits 7 and 6 set, bit 5 clear. Every register reads 0 in every mode.
- R2: Both read ports return the selected register combinationally. A register write lands at the rising edge. A read of the index being written in that same cycle returns the old value.
- R3: In every mode other than fast interrupt, indices 0 to 12 and 15 select one common set of registers. In fast-interrupt mode, indices 0 to 7 and 15 select that same common set.
- R4: Fast-interrupt, interrupt, supervisor, abort and undefined modes each own a private index 13 and index 14. User and system modes share one pair.
- R5: Fast-interrupt mode has private copies of indices 8 to 12. Writes to them in that mode leave the common copies that other modes see unchanged.
- R6: A current-status write replaces all 32 bits at the edge. The new mode field selects the banks from the next cycle on. A register write in the same cycle as a current-status write goes to the bank of the old mode.
- R7: In each of the five privileged modes, the saved-status port reads that mode's own saved word. A saved-status write stores into the word of the current mode.
- R8: In user and system modes the saved-status port reads 0. A saved-status write in those modes changes no saved word of any mode.
- R9: A mode field holding none of the seven encodings selects the user/system registers. In such a mode the saved-status port reads 0 and saved-status writes are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | DATA_W | Register write data |
| sr_wdata | input | 32 | Data for either status write |
| cpsr_wr | input | 1 | Current-status write strobe |
| spsr_wr | input | 1 | Saved-status write strobe for the current mode |
| cpsr_data | output | 32 | Current status word |
| spsr_data | output | 32 | Saved status word of the current mode, or 0 |

## Verification
Read data and the saved-status output are combinational in the present state, so they are due in the cycle they are requested. A register or status write becomes visible one clock edge later. A mode change also needs one edge before the banks follow it. For this reason the bench drives each cycle's inputs just after a falling edge and compares the outputs shortly afterwards against a model that has not yet taken that cycle's writes, which is exactly what the same-cycle old-value rule requires. It then applies the writes to the model at the rising edge, using the mode from before any status write in that cycle.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   typedef enum logic [4:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_ABT = 5'b10111,
      MODE_UND = 5'b11011,
      MODE_SYS = 5'b11111
   } mode_e;

   // saved-status / private-bank slot; SLOT_NONE means no private state
   typedef enum logic [2:0] {
      SLOT_FIQ  = 3'd0,
      SLOT_IRQ  = 3'd1,
      SLOT_SVC  = 3'd2,
      SLOT_ABT  = 3'd3,
      SLOT_UND  = 3'd4,
      SLOT_NONE = 3'd7
   } slot_e;

   localparam int NUM_PRIV   = 5;
   localparam int NUM_LOGIC  = 16;
   localparam int IDX_SP     = 13;
   localparam int IDX_LR     = 14;
   localparam int SR_W       = 32;
   localparam int MODE_W     = 5;
   localparam logic [SR_W-1:0] SR_RESET = 32'h0000_00D3;

   function automatic slot_e mode_slot(input logic [MODE_W-1:0] m);
      slot_e s;
      case (m)
         MODE_FIQ: s = SLOT_FIQ;
         MODE_IRQ: s = SLOT_IRQ;
         MODE_SVC: s = SLOT_SVC;
         MODE_ABT: s = SLOT_ABT;
         MODE_UND: s = SLOT_UND;
         default:  s = SLOT_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
   import bankreg_pkg::*;
#(
   parameter int FIQ_LO = 8,
   parameter int PHYS_W = 5
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [3:0]        idx,
   output logic [PHYS_W-1:0] phys
);
   localparam int NFIQ     = IDX_LR - FIQ_LO + 1;
   localparam int FIQ_BASE = NUM_LOGIC;
   localparam int PRV_BASE = NUM_LOGIC + NFIQ;

   slot_e slot;
   int    p;

   always_comb begin
      slot = mode_slot(mode);
      p    = int'(idx);
      if (slot == SLOT_FIQ && int'(idx) >= FIQ_LO && int'(idx) <= IDX_LR)
         p = FIQ_BASE + int'(idx) - FIQ_LO;
      else if (slot != SLOT_FIQ && slot != SLOT_NONE &&
               (int'(idx) == IDX_SP || int'(idx) == IDX_LR))
         p = PRV_BASE + 2 * (int'(slot) - 1) + (int'(idx) - IDX_SP);
      phys = p[PHYS_W-1:0];
   end

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
   parameter int DATA_W = 32,
   parameter int NPHYS  = 31,
   parameter int PHYS_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PHYS_W-1:0] wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [PHYS_W-1:0] ra0,
   output logic [DATA_W-1:0] rd0,
   input  logic [PHYS_W-1:0] ra1,
   output logic [DATA_W-1:0] rd1
);
   logic [DATA_W-1:0] cells [NPHYS];

   for (genvar g = 0; g < NPHYS; g++) begin : g_cell
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && wa == PHYS_W'(g))
            q <= wd;
      end
      assign cells[g] = q;
   end

   assign rd0 = cells[ra0];
   assign rd1 = cells[ra1];

endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
   import bankreg_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpsr_we,
   input  logic            spsr_we,
   input  logic [SR_W-1:0] wdata,
   output logic [SR_W-1:0] cpsr_q,
   output logic [SR_W-1:0] spsr_q
);
   logic [SR_W-1:0] saved [NUM_PRIV];
   slot_e           slot;

   assign slot = mode_slot(cpsr_q[MODE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cpsr_q <= SR_RESET;
      else if (cpsr_we)
         cpsr_q <= wdata;
   end

   for (genvar s = 0; s < NUM_PRIV; s++) begin : g_saved
      logic [SR_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (spsr_we && slot == slot_e'(s))
            q <= wdata;
      end
      assign saved[s] = q;
   end

   always_comb begin
      if (slot == SLOT_NONE)
         spsr_q = '0;
      else
         spsr_q = saved[slot];
   end

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
   import bankreg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int FIQ_LO = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [31:0]       sr_wdata,
   input  logic              cpsr_wr,
   input  logic              spsr_wr,
   output logic [31:0]       cpsr_data,
   output logic [31:0]       spsr_data
);
   localparam int NFIQ   = IDX_LR - FIQ_LO + 1;
   localparam int NPHYS  = NUM_LOGIC + NFIQ + 2 * (NUM_PRIV - 1);
   localparam int PHYS_W = $clog2(NPHYS);

   if (DATA_W < 8) begin : g_bad_width
      $error("bankreg_file: DATA_W must be at least 8");
   end
   if (FIQ_LO < 8 || FIQ_LO > IDX_SP) begin : g_bad_fiq
      $error("bankreg_file: FIQ_LO must lie in 8..13");
   end

   logic [PHYS_W-1:0] pa_a, pa_b, pa_w;
   logic [MODE_W-1:0] mode;

   assign mode = cpsr_data[MODE_W-1:0];

   bankreg_map #(.FIQ_LO(FIQ_LO), .PHYS_W(PHYS_W)) u_map_a (
      .mode(mode), .idx(rd_a_idx), .phys(pa_a));
   bankreg_map #(.FIQ_LO(FIQ_LO), .PHYS_W(PHYS_W)) u_map_b (
      .mode(mode), .idx(rd_b_idx), .phys(pa_b));
   bankreg_map #(.FIQ_LO(FIQ_LO), .PHYS_W(PHYS_W)) u_map_w (
      .mode(mode), .idx(wr_idx), .phys(pa_w));

   bankreg_store #(.DATA_W(DATA_W), .NPHYS(NPHYS), .PHYS_W(PHYS_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en), .wa(pa_w), .wd(wr_data),
      .ra0(pa_a), .rd0(rd_a_data),
      .ra1(pa_b), .rd1(rd_b_data));

   bankreg_status u_status (
      .clk(clk), .rst_n(rst_n),
      .cpsr_we(cpsr_wr), .spsr_we(spsr_wr), .wdata(sr_wdata),
      .cpsr_q(cpsr_data), .spsr_q(spsr_data));

endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk
   import bankreg_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic [31:0]       sr_wdata,
   input logic              cpsr_wr,
   input logic              spsr_wr,
   input logic [31:0]       cpsr_data,
   input logic [31:0]       spsr_data
);
   logic is_priv, is_plain;
   assign is_priv  = mode_slot(cpsr_data[MODE_W-1:0]) != SLOT_NONE;
   assign is_plain = cpsr_data[MODE_W-1:0] == MODE_USR ||
                     cpsr_data[MODE_W-1:0] == MODE_SYS;

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> cpsr_data == SR_RESET);

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && wr_en && !cpsr_wr) |=>
         (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

   assert_read_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !wr_en && !cpsr_wr) |=>
         (!$stable(rd_a_idx) || $stable(rd_a_data)));

   assert_status_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && cpsr_wr) |=> cpsr_data == $past(sr_wdata));

   assert_saved_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && spsr_wr && !cpsr_wr && is_priv) |=> spsr_data == $past(sr_wdata));

   assert_saved_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_plain |-> spsr_data == 32'h0);

endmodule

bind bankreg_file bankreg_file_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
   .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .sr_wdata(sr_wdata), .cpsr_wr(cpsr_wr), .spsr_wr(spsr_wr),
   .cpsr_data(cpsr_data), .spsr_data(spsr_data));

// File: tb/bankreg_file_test.sv
module bankreg_file_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic [31:0] sr_wdata = '0, cpsr_data, spsr_data;
   logic        wr_en = 1'b0, cpsr_wr = 1'b0, spsr_wr = 1'b0;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   bankreg_file uut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sr_wdata(sr_wdata), .cpsr_wr(cpsr_wr), .spsr_wr(spsr_wr),
      .cpsr_data(cpsr_data), .spsr_data(spsr_data));

   // reference state, laid out per requirement
   logic [31:0] m_common [16];
   logic [31:0] m_fast   [16];   // entries 8..14 used
   logic [31:0] m_sp     [5];
   logic [31:0] m_lr     [5];
   logic [31:0] m_saved  [5];
   logic [31:0] m_cur;

   // -1 user/system/unknown, 0 fast, 1 irq, 2 svc, 3 abort, 4 undefined
   function automatic int owner(input logic [4:0] m);
      if (m == 5'b10001) return 0;
      if (m == 5'b10010) return 1;
      if (m == 5'b10011) return 2;
      if (m == 5'b10111) return 3;
      if (m == 5'b11011) return 4;
      return -1;
   endfunction

   function automatic logic [31:0] want_reg(input logic [3:0] i);
      int o = owner(m_cur[4:0]);
      if (o == 0 && i >= 8 && i <= 14) return m_fast[i];
      if (o > 0 && i == 13) return m_sp[o];
      if (o > 0 && i == 14) return m_lr[o];
      if (o < 0 && i == 13) return m_sp[4 - 4];
      return m_common[i];
   endfunction

   function automatic logic [31:0] want_saved();
      int o = owner(m_cur[4:0]);
      return (o < 0) ? 32'h0 : m_saved[o];
   endfunction

   function automatic string tag_reg(input logic [3:0] i);
      int o = owner(m_cur[4:0]);
      if (i == 13 || i == 14) return "R4";
      if (o == 0 && i >= 8) return "R5";
      if (o < 0 && m_cur[4:0] != 5'b10000 && m_cur[4:0] != 5'b11111) return "R9";
      return "R3";
   endfunction

   function automatic string tag_saved();
      if (owner(m_cur[4:0]) >= 0) return "R7";
      if (m_cur[4:0] == 5'b10000 || m_cur[4:0] == 5'b11111) return "R8";
      return "R9";
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp,
                        input string req, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // user/system stack pointer kept in separate storage from privileged ones
   logic [31:0] m_usp, m_ulr;

   function automatic logic [31:0] want(input logic [3:0] i);
      int o = owner(m_cur[4:0]);
      if (o < 0 && i == 13) return m_usp;
      if (o < 0 && i == 14) return m_ulr;
      if (o == 0 && i >= 8 && i <= 14) return m_fast[i];
      if (o > 0 && i == 13) return m_sp[o];
      if (o > 0 && i == 14) return m_lr[o];
      return m_common[i];
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 16; k++) begin
         m_common[k] = '0;
         m_fast[k]   = '0;
      end
      for (int k = 0; k < 5; k++) begin
         m_sp[k] = '0; m_lr[k] = '0; m_saved[k] = '0;
      end
      m_usp = '0; m_ulr = '0;
      m_cur = 32'h0000_00D3;
   endtask

   task automatic model_commit(input logic we, input logic [3:0] wi, input logic [31:0] wd,
                               input logic cw, input logic sw, input logic [31:0] sd);
      int o = owner(m_cur[4:0]);
      if (we) begin
         if (o < 0 && wi == 13) m_usp = wd;
         else if (o < 0 && wi == 14) m_ulr = wd;
         else if (o == 0 && wi >= 8 && wi <= 14) m_fast[wi] = wd;
         else if (o > 0 && wi == 13) m_sp[o] = wd;
         else if (o > 0 && wi == 14) m_lr[o] = wd;
         else m_common[wi] = wd;
      end
      if (sw && o >= 0) m_saved[o] = sd;
      if (cw) m_cur = sd;
   endtask

   // one clock cycle: drive, compare against pre-edge model, commit at edge
   task automatic step(input logic we, input logic [3:0] wi, input logic [31:0] wd,
                       input logic cw, input logic sw, input logic [31:0] sd,
                       input logic [3:0] ra, input logic [3:0] rb, input string force_tag);
      @(negedge clk);
      wr_en = we; wr_idx = wi; wr_data = wd;
      cpsr_wr = cw; spsr_wr = sw; sr_wdata = sd;
      rd_a_idx = ra; rd_b_idx = rb;
      #1;
      check(rd_a_data, want(ra), (force_tag != "") ? force_tag : tag_reg(ra), "port A");
      check(rd_b_data, want(rb), (force_tag != "") ? force_tag : tag_reg(rb), "port B");
      check(cpsr_data, m_cur, "R6", "current status");
      check(spsr_data, want_saved(), tag_saved(), "saved status");
      @(posedge clk);
      model_commit(we, wi, wd, cw, sw, sd);
   endtask

   function automatic logic [4:0] pick_mode(input int n);
      case (n)
         0: return 5'b10000;
         1: return 5'b10001;
         2: return 5'b10010;
         3: return 5'b10011;
         4: return 5'b10111;
         5: return 5'b11011;
         6: return 5'b11111;
         default: return 5'b10100;
      endcase
   endfunction

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      // R1: reset state seen while reset is still held
      @(negedge clk);
      check(cpsr_data, 32'h0000_00D3, "R1", "status in reset");
      rst_n = 1'b1;
      // R1: every register reads zero after reset
      for (int k = 0; k < 16; k += 2)
         step(0, 0, 0, 0, 0, 0, 4'(k), 4'(k + 1), "R1");

      // R2: write r5 then overwrite it while reading: old value returned
      step(1, 5, 32'h0000_0055, 0, 0, 0, 5, 13, "");
      step(1, 5, 32'h0000_0066, 0, 0, 0, 5, 5, "R2");
      step(1, 13, 32'hA1A1_0013, 0, 0, 0, 5, 5, "R2");
      // R6: mode change to interrupt mode with a same-cycle write to r14 (lands in supervisor bank)
      step(1, 14, 32'hB0B0_0014, 1, 0, 32'hF000_0092, 13, 14, "");
      // R4: interrupt mode sees its own empty r13/r14, R3: common r5 visible
      step(1, 13, 32'h1111_0013, 0, 1, 32'h2000_0010, 13, 5, "");
      // R7: saved status of interrupt mode
      step(0, 0, 0, 1, 0, 32'h0000_0011, 13, 14, "");
      // R5: fast-interrupt private r8..r12
      step(1, 8, 32'hC8C8_C8C8, 0, 0, 0, 8, 12, "");
      step(1, 12, 32'hCCCC_0012, 0, 0, 0, 8, 13, "");
      step(0, 0, 0, 1, 0, 32'h0000_0010, 8, 12, "");
      // R8: user mode sees common r8/r12 and drops saved-status writes
      step(0, 0, 0, 0, 1, 32'hDEAD_BEEF, 8, 12, "R5");
      step(0, 0, 0, 0, 0, 0, 13, 14, "R4");
      // R9: unknown mode shares user registers and has no saved status
      step(1, 13, 32'h9999_0013, 1, 0, 32'h0000_0014, 13, 14, "");
      step(0, 0, 0, 0, 1, 32'h1234_5678, 13, 14, "R9");
      step(0, 0, 0, 1, 0, 32'h0000_001F, 13, 14, "");
      step(0, 0, 0, 1, 0, 32'h0000_0013, 13, 14, "R9");
      step(0, 0, 0, 0, 0, 0, 13, 14, "R4");

      for (int n = 0; n < 4000; n++) begin
         logic [3:0] wi, ra, rb;
         logic we, cw, sw;
         logic [31:0] sd;
         we = ($urandom % 2) == 0;
         cw = ($urandom % 8) == 0;
         sw = ($urandom % 6) == 0;
         wi = (($urandom % 3) == 0) ? 4'(13 + $urandom % 2) : 4'($urandom % 16);
         ra = (($urandom % 3) == 0) ? 4'(8 + $urandom % 7) : 4'($urandom % 16);
         rb = 4'($urandom % 16);
         sd = {$urandom} & 32'hF000_00E0;
         sd[4:0] = pick_mode(int'($urandom % 8));
         step(we, wi, $urandom, cw, sw, sd, ra, rb, "");
      end

      @(negedge clk);
      wr_en = 0; cpsr_wr = 0; spsr_wr = 0;
      finish_run();
   end

endmodule